// File: doc/BRIEF.md
# Hub Downstream Port State Controller

This block runs the life cycle of one downstream port of a hub. It watches the filtered line state of the port and the commands that the hub logic sends. From these it tracks whether the port is powered, connected, enabled, suspended, in reset or resuming. It asks the port transceiver to drive SE0 during a port reset and to drive K during resume. At all other times it asks the transceiver to leave the line released.

Every timed decision is a cycle count of a 30 MHz clock, and each count is a parameter:
- a device must hold the line out of SE0 for 75 cycles (2.5 µs) before a connect is accepted;
- SE0 must persist for 68 cycles (about 2.27 µs) before a disconnect is accepted;
- a port reset drives SE0 for 450000 cycles (15 ms);
- resume drives K for 600000 cycles (20 ms).

When a suspended device signals wake-up with K, the block pulses a request to send the resume upstream. It raises this pulse in the same cycle that it starts driving K, which is far inside the 1 ms allowance. Four sticky change flags record events for the hub's status reporting.

Top module: `dport_ctrl`

## Requirements
- R1: While reset is held and for as long as `portPower` is low afterwards, all five status outputs, both drive outputs, `changeBits` and `resumeUp` are 0.
- R2: `lineState` is encoded as 2'b00 = SE0, 2'b01 = J, 2'b10 = K; 2'b11 counts as neither SE0 nor K. While the port is disconnected and powered, the line must leave SE0 for CONN_CYCLES consecutive cycles. One cycle later the port becomes connected but disabled, and `changeBits[0]` is set. Any SE0 cycle within that window restarts the count.
- R3: In the disabled, enabled or suspended state, SE0 for DISC_CYCLES consecutive cycles returns the port to disconnected one cycle later. This clears connected and enabled and sets `changeBits[0]`.
- R4: `cmdReset` in the disabled, enabled or suspended state starts a port reset. `driveSe0` is then high for exactly RESET_CYCLES cycles, after which the port is enabled and `changeBits[3]` is set. `cmdReset` has no effect while the port is disconnected.
- R5: In the enabled state, `cmdDisable` or `babble` moves the port to disabled on the next cycle and sets `changeBits[1]`.
- R6: `cmdSuspend` in the enabled state suspends the port. After that, `cmdResume` drives K for exactly RESUME_CYCLES cycles. The port then returns to enabled with `stSuspended` low and `changeBits[2]` set.
- R7: In the suspended state, K on the line for WAKE_CYCLES consecutive cycles starts resume one cycle later. `resumeUp` is high for exactly that first cycle of the resume drive.
- R8: A low `portPower` puts the port in the powered-off state on the next cycle from any state, and releases both drives.
- R9: Each `changeBits` flag stays set until the matching `clrChange` bit is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R10: `driveSe0` and `driveK` are never high together. Reset drives only SE0 and resume drives only K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (30 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| portPower | input | 1 | Port power is applied |
| lineState | input | 2 | Sampled line state: 00 SE0, 01 J, 10 K |
| cmdReset | input | 1 | One-cycle request to reset the port |
| cmdSuspend | input | 1 | One-cycle request to suspend the port |
| cmdResume | input | 1 | One-cycle request to end suspend |
| cmdDisable | input | 1 | One-cycle request to disable the port |
| babble | input | 1 | Babble seen on the enabled port |
| clrChange | input | 4 | Clear strobes for the change flags |
| driveSe0 | output | 1 | Ask the transceiver to drive SE0 |
| driveK | output | 1 | Ask the transceiver to drive K |
| stPowered | output | 1 | Port is powered |
| stConnected | output | 1 | Device is connected |
| stEnabled | output | 1 | Port is enabled (including suspend and resume) |
| stSuspended | output | 1 | Port is suspended or resuming |
| stReset | output | 1 | Port reset in progress |
| changeBits | output | 4 | Sticky flags: 0 connect, 1 enable, 2 suspend, 3 reset |
| resumeUp | output | 1 | One-cycle request to forward resume upstream |

## Verification
A command takes effect one clock after the cycle in which it is sampled. A line filter of N cycles changes the port state on clock N+1 after the line changes. A drive that is N cycles long drops exactly N clocks after it starts. Inputs are changed on the falling edge. Each filter and each drive is checked on both sides of its boundary: once at the cycle count where nothing may have changed yet, and once a single cycle later where the change must be visible. The `resumeUp` pulse is sampled in its one cycle and again in the cycle after it.

// File: rtl/dport_pkg.sv
`timescale 1ns/1ps
package dport_pkg;

  typedef enum logic [2:0] {
    PS_OFF       = 3'd0,
    PS_DISCONN   = 3'd1,
    PS_DISABLED  = 3'd2,
    PS_RESETTING = 3'd3,
    PS_ENABLED   = 3'd4,
    PS_SUSPENDED = 3'd5,
    PS_RESUMING  = 3'd6
  } portState_e;

  localparam logic [1:0] LINE_SE0 = 2'b00;
  localparam logic [1:0] LINE_K   = 2'b10;

  localparam int CHG_CONNECT = 0;
  localparam int CHG_ENABLE  = 1;
  localparam int CHG_SUSPEND = 2;
  localparam int CHG_RESET   = 3;

  // strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic restart;   // state changes at this edge: clear filters and timer
    logic connWatch; // count non-SE0 cycles
    logic discWatch; // count SE0 cycles
    logic kWatch;    // count K cycles
    logic timerRun;  // advance the drive timer
  } dpStrobe_t;

endpackage

// File: rtl/dport_filter.sv
`timescale 1ns/1ps
module dport_filter #(
  parameter int unsigned LIMIT = 75
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic cond,
  output logic qual
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr || !cond) begin
      cnt <= '0;
    end else if (cnt != W'(LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign qual = (cnt == W'(LIMIT));

  // a filter can only become qualified after an uninterrupted condition
  assert_filter_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qual) |-> ($past(cond) && !$past(clr)));

endmodule

// File: rtl/dport_timing.sv
`timescale 1ns/1ps
module dport_timing
  import dport_pkg::*;
#(
  parameter int unsigned CONN_CYCLES   = 75,
  parameter int unsigned DISC_CYCLES   = 68,
  parameter int unsigned WAKE_CYCLES   = 75,
  parameter int unsigned RESET_CYCLES  = 450000,
  parameter int unsigned RESUME_CYCLES = 600000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lineState,
  input  dpStrobe_t  strb,
  output logic       connQual,
  output logic       discQual,
  output logic       kQual,
  output logic       resetDone,
  output logic       resumeDone
);
  localparam int unsigned TMAX = (RESET_CYCLES > RESUME_CYCLES) ? RESET_CYCLES : RESUME_CYCLES;
  localparam int TW = $clog2(TMAX + 1);
  localparam int NFILT = 3;

  logic isSe0, isK;
  logic [NFILT-1:0] filtCond, filtQual;

  assign isSe0 = (lineState == LINE_SE0);
  assign isK   = (lineState == LINE_K);

  // index 0: connect, 1: disconnect, 2: wake-up K
  assign filtCond = {strb.kWatch && isK, strb.discWatch && isSe0, strb.connWatch && !isSe0};

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    localparam int unsigned LIM = (g == 0) ? CONN_CYCLES : ((g == 1) ? DISC_CYCLES : WAKE_CYCLES);
    dport_filter #(.LIMIT(LIM)) u_filt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strb.restart),
      .cond (filtCond[g]),
      .qual (filtQual[g])
    );
  end

  assign connQual = filtQual[0];
  assign discQual = filtQual[1];
  assign kQual    = filtQual[2];

  // drive timer: zero at state entry, one step per cycle in a drive state
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (strb.restart || !strb.timerRun) begin
      tmr <= '0;
    end else if (tmr != TW'(TMAX)) begin
      tmr <= tmr + 1'b1;
    end
  end

  assign resetDone  = (tmr == TW'(RESET_CYCLES - 1));
  assign resumeDone = (tmr == TW'(RESUME_CYCLES - 1));

endmodule

// File: rtl/dport_seq.sv
`timescale 1ns/1ps
module dport_seq
  import dport_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       portPower,
  input  logic       cmdReset,
  input  logic       cmdSuspend,
  input  logic       cmdResume,
  input  logic       cmdDisable,
  input  logic       babble,
  input  logic [3:0] clrChange,
  input  logic       connQual,
  input  logic       discQual,
  input  logic       kQual,
  input  logic       resetDone,
  input  logic       resumeDone,
  output dpStrobe_t  strb,
  output logic       driveSe0,
  output logic       driveK,
  output logic       stPowered,
  output logic       stConnected,
  output logic       stEnabled,
  output logic       stSuspended,
  output logic       stReset,
  output logic [3:0] changeBits,
  output logic       resumeUp
);
  portState_e state, nextState;
  logic [3:0] setVec;
  logic       wakeDet;

  always_comb begin
    nextState = state;
    setVec    = '0;
    wakeDet   = 1'b0;
    if (!portPower) begin
      nextState = PS_OFF;
    end else begin
      case (state)
        PS_OFF: nextState = PS_DISCONN;
        PS_DISCONN: begin
          if (connQual) begin
            nextState = PS_DISABLED;
            setVec[CHG_CONNECT] = 1'b1;
          end
        end
        PS_DISABLED: begin
          if (discQual) begin
            nextState = PS_DISCONN;
            setVec[CHG_CONNECT] = 1'b1;
          end else if (cmdReset) begin
            nextState = PS_RESETTING;
          end
        end
        PS_RESETTING: begin
          if (resetDone) begin
            nextState = PS_ENABLED;
            setVec[CHG_RESET] = 1'b1;
          end
        end
        PS_ENABLED: begin
          if (discQual) begin
            nextState = PS_DISCONN;
            setVec[CHG_CONNECT] = 1'b1;
          end else if (cmdReset) begin
            nextState = PS_RESETTING;
          end else if (cmdDisable || babble) begin
            nextState = PS_DISABLED;
            setVec[CHG_ENABLE] = 1'b1;
          end else if (cmdSuspend) begin
            nextState = PS_SUSPENDED;
          end
        end
        PS_SUSPENDED: begin
          if (discQual) begin
            nextState = PS_DISCONN;
            setVec[CHG_CONNECT] = 1'b1;
          end else if (cmdReset) begin
            nextState = PS_RESETTING;
          end else if (cmdDisable) begin
            nextState = PS_DISABLED;
            setVec[CHG_ENABLE] = 1'b1;
          end else if (kQual) begin
            nextState = PS_RESUMING;
            wakeDet   = 1'b1;
          end else if (cmdResume) begin
            nextState = PS_RESUMING;
          end
        end
        PS_RESUMING: begin
          if (resumeDone) begin
            nextState = PS_ENABLED;
            setVec[CHG_SUSPEND] = 1'b1;
          end
        end
        default: nextState = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= PS_OFF;
      changeBits <= '0;
      resumeUp   <= 1'b0;
    end else begin
      state      <= nextState;
      changeBits <= (changeBits & ~clrChange) | setVec;
      resumeUp   <= wakeDet;
    end
  end

  always_comb begin
    strb.restart   = (nextState != state);
    strb.connWatch = (state == PS_DISCONN);
    strb.discWatch = (state == PS_DISABLED) || (state == PS_ENABLED) || (state == PS_SUSPENDED);
    strb.kWatch    = (state == PS_SUSPENDED);
    strb.timerRun  = (state == PS_RESETTING) || (state == PS_RESUMING);
  end

  assign driveSe0    = (state == PS_RESETTING);
  assign driveK      = (state == PS_RESUMING);
  assign stPowered   = (state != PS_OFF);
  assign stConnected = (state != PS_OFF) && (state != PS_DISCONN);
  assign stEnabled   = (state == PS_ENABLED) || (state == PS_SUSPENDED) || (state == PS_RESUMING);
  assign stSuspended = (state == PS_SUSPENDED) || (state == PS_RESUMING);
  assign stReset     = (state == PS_RESETTING);

  assert_power_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !portPower |=> (state == PS_OFF));

  // the drive timer must be cleared when a reset begins
  assert_reset_fresh_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((state == PS_RESETTING) && ($past(state) != PS_RESETTING)) |-> !resetDone);

  assert_disable_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == PS_ENABLED) && portPower && !discQual && !cmdReset && (cmdDisable || babble))
      |=> (state == PS_DISABLED));

  assert_wake_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    resumeUp |-> ((state == PS_RESUMING) && ($past(state) == PS_SUSPENDED)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((~changeBits) & $past(changeBits) & ~$past(clrChange)) == 4'b0000);

endmodule

// File: rtl/dport_ctrl.sv
`timescale 1ns/1ps
module dport_ctrl
  import dport_pkg::*;
#(
  parameter int unsigned CONN_CYCLES   = 75,
  parameter int unsigned DISC_CYCLES   = 68,
  parameter int unsigned WAKE_CYCLES   = 75,
  parameter int unsigned RESET_CYCLES  = 450000,
  parameter int unsigned RESUME_CYCLES = 600000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portPower,
  input  logic [1:0] lineState,
  input  logic       cmdReset,
  input  logic       cmdSuspend,
  input  logic       cmdResume,
  input  logic       cmdDisable,
  input  logic       babble,
  input  logic [3:0] clrChange,
  output logic       driveSe0,
  output logic       driveK,
  output logic       stPowered,
  output logic       stConnected,
  output logic       stEnabled,
  output logic       stSuspended,
  output logic       stReset,
  output logic [3:0] changeBits,
  output logic       resumeUp
);
  dpStrobe_t strb;
  logic connQual, discQual, kQual, resetDone, resumeDone;

  dport_timing #(
    .CONN_CYCLES   (CONN_CYCLES),
    .DISC_CYCLES   (DISC_CYCLES),
    .WAKE_CYCLES   (WAKE_CYCLES),
    .RESET_CYCLES  (RESET_CYCLES),
    .RESUME_CYCLES (RESUME_CYCLES)
  ) u_timing (
    .clk        (clk),
    .rstN       (rstN),
    .lineState  (lineState),
    .strb       (strb),
    .connQual   (connQual),
    .discQual   (discQual),
    .kQual      (kQual),
    .resetDone  (resetDone),
    .resumeDone (resumeDone)
  );

  dport_seq u_seq (
    .clk         (clk),
    .rstN        (rstN),
    .portPower   (portPower),
    .cmdReset    (cmdReset),
    .cmdSuspend  (cmdSuspend),
    .cmdResume   (cmdResume),
    .cmdDisable  (cmdDisable),
    .babble      (babble),
    .clrChange   (clrChange),
    .connQual    (connQual),
    .discQual    (discQual),
    .kQual       (kQual),
    .resetDone   (resetDone),
    .resumeDone  (resumeDone),
    .strb        (strb),
    .driveSe0    (driveSe0),
    .driveK      (driveK),
    .stPowered   (stPowered),
    .stConnected (stConnected),
    .stEnabled   (stEnabled),
    .stSuspended (stSuspended),
    .stReset     (stReset),
    .changeBits  (changeBits),
    .resumeUp    (resumeUp)
  );

endmodule

// File: tb/test_dport_ctrl.sv
`timescale 1ns/1ps
module test_dport_ctrl;
  localparam int CONN = 75;
  localparam int DISC = 68;
  localparam int WAKE = 75;
  localparam int RST  = 400;
  localparam int RES  = 500;

  logic clk = 1'b0;
  logic rstN, portPower, cmdReset, cmdSuspend, cmdResume, cmdDisable, babble;
  logic [1:0] lineState;
  logic [3:0] clrChange;
  logic driveSe0, driveK, stPowered, stConnected, stEnabled, stSuspended, stReset, resumeUp;
  logic [3:0] changeBits;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  dport_ctrl #(
    .CONN_CYCLES(CONN), .DISC_CYCLES(DISC), .WAKE_CYCLES(WAKE),
    .RESET_CYCLES(RST), .RESUME_CYCLES(RES)
  ) i_dport_ctrl (
    .clk(clk), .rstN(rstN), .portPower(portPower), .lineState(lineState),
    .cmdReset(cmdReset), .cmdSuspend(cmdSuspend), .cmdResume(cmdResume),
    .cmdDisable(cmdDisable), .babble(babble), .clrChange(clrChange),
    .driveSe0(driveSe0), .driveK(driveK), .stPowered(stPowered),
    .stConnected(stConnected), .stEnabled(stEnabled), .stSuspended(stSuspended),
    .stReset(stReset), .changeBits(changeBits), .resumeUp(resumeUp)
  );

  // {powered, connected, enabled, suspended, reset}
  function automatic logic [4:0] stVec();
    return {stPowered, stConnected, stEnabled, stSuspended, stReset};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // 0 reset, 1 suspend, 2 resume, 3 disable, 4 babble
  task automatic pulseCmd(input int which);
    case (which)
      0: cmdReset   = 1'b1;
      1: cmdSuspend = 1'b1;
      2: cmdResume  = 1'b1;
      3: cmdDisable = 1'b1;
      default: babble = 1'b1;
    endcase
    tick(1);
    {cmdReset, cmdSuspend, cmdResume, cmdDisable, babble} = '0;
  endtask

  task automatic pulseClr(input logic [3:0] bits);
    clrChange = bits;
    tick(1);
    clrChange = '0;
  endtask

  task automatic doReset();
    pulseCmd(0);
    tick(RST);
    pulseClr(4'b1000);
  endtask

  task automatic t_reset_state();
    chk("R1 status", stVec(), 5'b00000);
    chk("R1 drives", {driveSe0, driveK}, 2'b00);
    chk("R1 change", changeBits, 4'b0000);
    chk("R1 resumeUp", resumeUp, 1'b0);
  endtask

  task automatic t_connect();
    portPower = 1'b1;
    tick(1);
    chk("R2 powered, disconnected", stVec(), 5'b10000);
    pulseCmd(0);
    tick(1);
    chk("R4 reset ignored while disconnected", {driveSe0, driveK}, 2'b00);
    lineState = 2'b01;
    tick(40);
    lineState = 2'b00;
    tick(1);
    lineState = 2'b01;
    tick(CONN);
    chk("R2 filter restarted by SE0", stVec(), 5'b10000);
    tick(1);
    chk("R2 connected", stVec(), 5'b11000);
    chk("R2 connect change", changeBits, 4'b0001);
    tick(5);
    chk("R9 flag sticky", changeBits, 4'b0001);
    pulseClr(4'b0001);
    chk("R9 flag cleared", changeBits, 4'b0000);
  endtask

  task automatic t_port_reset();
    pulseCmd(0);
    chk("R4 reset drive start", {driveSe0, driveK}, 2'b10);
    chk("R10 reset drives SE0 only", {driveSe0, driveK}, 2'b10);
    chk("R4 in reset", stVec(), 5'b11001);
    tick(RST - 1);
    chk("R4 drive still on", driveSe0, 1'b1);
    tick(1);
    chk("R4 drive released", {driveSe0, driveK}, 2'b00);
    chk("R4 enabled after reset", stVec(), 5'b11100);
    chk("R4 reset change", changeBits, 4'b1000);
    pulseClr(4'b1000);
  endtask

  task automatic t_disable();
    pulseCmd(4);
    chk("R5 babble disables", stVec(), 5'b11000);
    chk("R5 enable change", changeBits, 4'b0010);
    pulseClr(4'b0010);
    doReset();
    chk("R5 re-enabled", stVec(), 5'b11100);
    cmdDisable = 1'b1;
    clrChange  = 4'b0010;
    tick(1);
    cmdDisable = 1'b0;
    clrChange  = 4'b0000;
    chk("R5 command disables", stVec(), 5'b11000);
    chk("R9 set wins over clear", changeBits, 4'b0010);
    pulseClr(4'b0010);
  endtask

  task automatic t_host_resume();
    doReset();
    pulseCmd(1);
    chk("R6 suspended", stVec(), 5'b11110);
    tick(10);
    chk("R6 suspend holds", stVec(), 5'b11110);
    pulseCmd(2);
    chk("R6 K drive start", {driveSe0, driveK}, 2'b01);
    chk("R10 resume drives K only", {driveSe0, driveK}, 2'b01);
    tick(RES - 1);
    chk("R6 K drive still on", driveK, 1'b1);
    tick(1);
    chk("R6 drive released", {driveSe0, driveK}, 2'b00);
    chk("R6 enabled after resume", stVec(), 5'b11100);
    chk("R6 suspend change", changeBits, 4'b0100);
    pulseClr(4'b0100);
  endtask

  task automatic t_remote_wake();
    pulseCmd(1);
    lineState = 2'b10;
    tick(WAKE);
    chk("R7 before filter end", {stVec(), driveK, resumeUp}, {5'b11110, 2'b00});
    tick(1);
    chk("R7 resume started", {driveK, resumeUp}, 2'b11);
    tick(1);
    chk("R7 upstream pulse one cycle", {driveK, resumeUp}, 2'b10);
    lineState = 2'b01;
    tick(RES - 1);
    chk("R7 resume done", {stVec(), driveK}, {5'b11100, 1'b0});
    chk("R7 suspend change", changeBits, 4'b0100);
    pulseClr(4'b0100);
  endtask

  task automatic t_disconnect();
    lineState = 2'b00;
    tick(DISC);
    chk("R3 before filter end", stVec(), 5'b11100);
    tick(1);
    chk("R3 disconnected", stVec(), 5'b10000);
    chk("R3 connect change", changeBits, 4'b0001);
    pulseClr(4'b0001);
  endtask

  task automatic t_power_off();
    lineState = 2'b11;
    tick(CONN + 1);
    chk("R2 SE1 counts as not SE0", stVec(), 5'b11000);
    pulseClr(4'b0001);
    pulseCmd(0);
    tick(10);
    chk("R8 in reset before power loss", driveSe0, 1'b1);
    portPower = 1'b0;
    tick(1);
    chk("R8 powered off", stVec(), 5'b00000);
    chk("R8 drives released", {driveSe0, driveK}, 2'b00);
    portPower = 1'b1;
    tick(1);
    chk("R8 power back", stVec(), 5'b10000);
  endtask

  initial begin
    rstN = 1'b0; portPower = 1'b0; lineState = 2'b00; clrChange = '0;
    {cmdReset, cmdSuspend, cmdResume, cmdDisable, babble} = '0;
    tick(3);
    t_reset_state();
    rstN = 1'b1;
    tick(2);
    t_reset_state();
    t_connect();
    t_port_reset();
    t_disable();
    t_host_resume();
    t_remote_wake();
    t_disconnect();
    t_power_off();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule